// File: doc/BRIEF.md
# Key-locked IO delay register bank

This block is the configuration register file of an IO delay controller. A single 32-bit port, addressed by word index, gives access to three groups of registers. The first group is read-only calibration registers, fed from input ports. The second is a global lock register that only opens for a 16-bit key. The third is an array of per-pin delay words, with three words for each pin. Each delay word holds a coarse element count, a fine element count and a lock bit, which the delay lines elsewhere on the chip consume.

A per-pin word changes only when all three of these hold:
- the bank is open;
- the written value carries the fixed signature;
- the stored word has not already been locked.

A write that reaches an open bank but fails the signature or lock test is dropped and raises a sticky fault flag. A debug output gives the pin number of the last per-pin register that was touched. Byte offset = 4 × word index throughout.

Top module: `dly_regbank`

## Requirements
- R1: After synchronous reset the bank is closed, the fault flag, read data, read valid and debug pin are zero, and every per-pin word reads as zero.
- R2: Writing low half 0xAAAA to word 11 (byte 0x2C) opens the bank and 0xAAAB closes it. The upper 16 bits are ignored, and any other key leaves the state unchanged. Reading word 11 returns 0xAAAA while open and 0xAAAB while closed.
- R3: Word 5 reads {16'h0, reference period}. Word 6 reads {coarse delay count, coarse reference count} and word 7 reads {fine delay count, fine reference count}, with the delay count in bits 31:16. Writes to these words change nothing.
- R4: While the bank is closed, a write to a per-pin word (words 12 to 839) is ignored and does not raise the fault flag.
- R5: With the bank open, a per-pin write is stored when bits 17:12 equal 0x29 and the stored lock bit is clear. The stored fields are lock bit 10, coarse count bits 9:5 and fine count bits 4:0. The word then reads back with 0x29 in bits 17:12 and zeros in bits 31:18 and bit 11.
- R6: With the bank open, a per-pin write whose bits 17:12 differ from 0x29 is dropped and sets the fault flag.
- R7: With the bank open, a per-pin write to a word whose stored lock bit is 1 is dropped and sets the fault flag.
- R8: Reads of words that map to no register (0–4, 8–10, above 839) return zero, and writes to them change nothing.
- R9: Any access to word w in 12..839 sets the debug pin output to (w − 12)/3 on the next cycle. Other accesses leave it unchanged.
- R10: A read request gives its data and a one-cycle read-valid pulse on the cycle after the request. Read data holds between reads.
- R11: The fault flag stays set through later accepted writes and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_widx | input | AW (10) | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| cal_period | input | 16 | Reference clock period |
| cal_crs_dly | input | 16 | Coarse delay count |
| cal_crs_ref | input | 16 | Coarse reference count |
| cal_fin_dly | input | 16 | Fine delay count |
| cal_fin_ref | input | 16 | Fine reference count |
| bank_open | output | 1 | Global unlock state |
| cfg_fault | output | 1 | Sticky rejected-write flag |
| dbg_pin | output | PW (9) | Pin of last per-pin access |

## Verification
The hardest case to reach is a rejection caused by a per-register lock. It needs three steps in order: open the bank with the exact key, store a word whose lock bit is set, then write the same word again with a valid signature. Only that last write shows that the lock, and not the signature, refused it.

The stimulus scripts this sequence. It then resets to clear the sticky flag and sets up a signature-only rejection on its own. A long random mix of keys, signatures and lock bits then runs against the reference model, which is compared on every clock.

// File: rtl/dly_bank_pkg.sv
`timescale 1ns/1ps
package dly_bank_pkg;
    localparam int unsigned REF_WIDX      = 5;
    localparam int unsigned CRS_WIDX      = 6;
    localparam int unsigned FIN_WIDX      = 7;
    localparam int unsigned LOCK_WIDX     = 11;
    localparam int unsigned PIN_BASE_WIDX = 12;

    localparam logic [15:0] KEY_OPEN = 16'hAAAA;
    localparam logic [15:0] KEY_SHUT = 16'hAAAB;

    localparam int unsigned SIG_W    = 6;
    localparam int unsigned SIG_LSB  = 12;
    localparam logic [SIG_W-1:0] SIG_VAL = 6'h29;
    localparam int unsigned LOCK_BIT = 10;
    localparam int unsigned CNT_W    = 5;
    localparam int unsigned CRS_LSB  = 5;

    typedef enum logic [2:0] {
        AR_NONE, AR_REF, AR_CRS, AR_FIN, AR_LOCK, AR_PIN
    } area_e;

    typedef struct packed {
        logic             used;
        logic             lock;
        logic [CNT_W-1:0] crs;
        logic [CNT_W-1:0] fin;
    } slot_t;

    function automatic logic [31:0] slot_to_word(slot_t s);
        logic [31:0] w;
        w = '0;
        if (s.used) begin
            w[SIG_LSB +: SIG_W]   = SIG_VAL;
            w[LOCK_BIT]           = s.lock;
            w[CRS_LSB +: CNT_W]   = s.crs;
            w[CNT_W-1:0]          = s.fin;
        end
        return w;
    endfunction

    function automatic slot_t word_to_slot(logic [31:0] w);
        slot_t s;
        s.used = 1'b1;
        s.lock = w[LOCK_BIT];
        s.crs  = w[CRS_LSB +: CNT_W];
        s.fin  = w[CNT_W-1:0];
        return s;
    endfunction

    function automatic logic sig_ok(logic [31:0] w);
        return w[SIG_LSB +: SIG_W] == SIG_VAL;
    endfunction
endpackage

// File: rtl/dly_addr_dec.sv
`timescale 1ns/1ps
module dly_addr_dec
    import dly_bank_pkg::*;
#(
    parameter int unsigned AW           = 10,
    parameter int unsigned NUM_PINS     = 276,
    parameter int unsigned REGS_PER_PIN = 3,
    localparam int unsigned SLOTS = NUM_PINS * REGS_PER_PIN,
    localparam int unsigned SW    = $clog2(SLOTS),
    localparam int unsigned PW    = $clog2(NUM_PINS)
) (
    input  logic [AW-1:0] widx,
    output area_e         area,
    output logic [SW-1:0] slot,
    output logic [PW-1:0] pin
);
    localparam int unsigned LAST_WIDX = PIN_BASE_WIDX + SLOTS - 1;

    logic          in_pin;
    logic [AW-1:0] offs;

    assign in_pin = (widx >= AW'(PIN_BASE_WIDX)) && (widx <= AW'(LAST_WIDX));
    assign offs   = widx - AW'(PIN_BASE_WIDX);

    always_comb begin
        if (in_pin)                       area = AR_PIN;
        else if (widx == AW'(REF_WIDX))   area = AR_REF;
        else if (widx == AW'(CRS_WIDX))   area = AR_CRS;
        else if (widx == AW'(FIN_WIDX))   area = AR_FIN;
        else if (widx == AW'(LOCK_WIDX))  area = AR_LOCK;
        else                              area = AR_NONE;
    end

    assign slot = in_pin ? offs[SW-1:0] : '0;
    assign pin  = in_pin ? PW'(offs / AW'(REGS_PER_PIN)) : '0;
endmodule

// File: rtl/dly_key_lock.sv
`timescale 1ns/1ps
module dly_key_lock
    import dly_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_we,
    input  logic [15:0] key,
    output logic        open
);
    always_ff @(posedge clk) begin
        if (rst) begin
            open <= 1'b0;
        end else if (key_we) begin
            if (key == KEY_OPEN)      open <= 1'b1;
            else if (key == KEY_SHUT) open <= 1'b0;
        end
    end
endmodule

// File: rtl/dly_pin_store.sv
`timescale 1ns/1ps
module dly_pin_store
    import dly_bank_pkg::*;
#(
    parameter int unsigned SLOTS = 828,
    parameter int unsigned SW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          open,
    input  logic [SW-1:0] slot,
    input  logic [31:0]   wdata,
    output slot_t         rd_slot,
    output logic          fault
);
    slot_t mem [SLOTS];
    logic  accept;
    logic  reject;

    assign rd_slot = (int'(slot) < SLOTS) ? mem[slot] : '0;
    assign accept  = wr_en && open && sig_ok(wdata) && !rd_slot.lock;
    assign reject  = wr_en && open && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            fault <= 1'b0;
        end else begin
            if (accept) mem[slot] <= word_to_slot(wdata);
            if (reject) fault <= 1'b1;
        end
    end
endmodule

// File: rtl/dly_regbank.sv
`timescale 1ns/1ps
module dly_regbank
    import dly_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 276,
    parameter int unsigned REGS_PER_PIN = 3,
    parameter int unsigned AW           = 10,
    localparam int unsigned SLOTS = NUM_PINS * REGS_PER_PIN,
    localparam int unsigned SW    = $clog2(SLOTS),
    localparam int unsigned PW    = $clog2(NUM_PINS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_widx,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    input  logic [15:0]   cal_period,
    input  logic [15:0]   cal_crs_dly,
    input  logic [15:0]   cal_crs_ref,
    input  logic [15:0]   cal_fin_dly,
    input  logic [15:0]   cal_fin_ref,
    output logic          bank_open,
    output logic          cfg_fault,
    output logic [PW-1:0] dbg_pin
);
    area_e         area;
    logic [SW-1:0] slot;
    logic [PW-1:0] pin;
    slot_t         cur_slot;
    logic [31:0]   rd_mux;
    logic          do_rd;
    logic          do_wr;

    assign do_rd = bus_valid && !bus_write;
    assign do_wr = bus_valid &&  bus_write;

    dly_addr_dec #(
        .AW(AW), .NUM_PINS(NUM_PINS), .REGS_PER_PIN(REGS_PER_PIN)
    ) u_dec (
        .widx(bus_widx), .area(area), .slot(slot), .pin(pin)
    );

    dly_key_lock u_key (
        .clk(clk), .rst(rst),
        .key_we(do_wr && (area == AR_LOCK)),
        .key(bus_wdata[15:0]),
        .open(bank_open)
    );

    dly_pin_store #(.SLOTS(SLOTS), .SW(SW)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(do_wr && (area == AR_PIN)),
        .open(bank_open),
        .slot(slot),
        .wdata(bus_wdata),
        .rd_slot(cur_slot),
        .fault(cfg_fault)
    );

    always_comb begin
        unique case (area)
            AR_REF:  rd_mux = {16'h0, cal_period};
            AR_CRS:  rd_mux = {cal_crs_dly, cal_crs_ref};
            AR_FIN:  rd_mux = {cal_fin_dly, cal_fin_ref};
            AR_LOCK: rd_mux = {16'h0, bank_open ? KEY_OPEN : KEY_SHUT};
            AR_PIN:  rd_mux = slot_to_word(cur_slot);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            dbg_pin    <= '0;
        end else begin
            bus_rvalid <= do_rd;
            if (do_rd) bus_rdata <= rd_mux;
            if (bus_valid && (area == AR_PIN)) dbg_pin <= pin;
        end
    end
endmodule

// File: rtl/dly_bank_chk.sv
`timescale 1ns/1ps
module dly_bank_chk
    import dly_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 276,
    parameter int unsigned REGS_PER_PIN = 3,
    parameter int unsigned AW           = 10,
    localparam int unsigned PW = $clog2(NUM_PINS)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_widx,
    input logic [31:0]   bus_rdata,
    input logic          bus_rvalid,
    input logic          bank_open,
    input logic          cfg_fault,
    input logic [PW-1:0] dbg_pin
);
    localparam int unsigned LAST_WIDX = PIN_BASE_WIDX + NUM_PINS * REGS_PER_PIN - 1;

    // R2
    key_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank_open) |-> $past(bus_valid && bus_write && bus_widx == AW'(LOCK_WIDX)));

    // R2
    key_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_widx == AW'(LOCK_WIDX) && !bank_open)
        |=> bus_rdata == 32'h0000_AAAB);

    // R4
    shut_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (!bank_open && bus_valid && bus_write) |=> $stable(cfg_fault));

    // R8
    oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_widx > AW'(LAST_WIDX)) |=> bus_rdata == 32'h0);

    // R10
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R10
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_fault |=> cfg_fault);

    // R9
    pin_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(dbg_pin) < NUM_PINS);
endmodule

bind dly_regbank dly_bank_chk #(
    .NUM_PINS(NUM_PINS), .REGS_PER_PIN(REGS_PER_PIN), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_widx(bus_widx), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bank_open(bank_open), .cfg_fault(cfg_fault), .dbg_pin(dbg_pin)
);

// File: tb/dly_regbank_test.sv
`timescale 1ns/1ps
module dly_regbank_test;
    localparam int AW = 10;
    localparam int PW = 9;
    localparam int LAST = 839;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_widx = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [15:0]   cal_period  = 16'h1234;
    logic [15:0]   cal_crs_dly = 16'h00A5;
    logic [15:0]   cal_crs_ref = 16'h0C3C;
    logic [15:0]   cal_fin_dly = 16'h005A;
    logic [15:0]   cal_fin_ref = 16'h0F0F;
    logic          bank_open;
    logic          cfg_fault;
    logic [PW-1:0] dbg_pin;

    int    n_tot = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    mdl_live = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_pin [int];
    bit          m_open;
    bit          m_err;
    int          m_dbg;
    bit          e_rv;
    logic [31:0] e_rd;

    always #10 clk = ~clk;

    dly_regbank uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cal_period(cal_period), .cal_crs_dly(cal_crs_dly),
        .cal_crs_ref(cal_crs_ref), .cal_fin_dly(cal_fin_dly), .cal_fin_ref(cal_fin_ref),
        .bank_open(bank_open), .cfg_fault(cfg_fault), .dbg_pin(dbg_pin)
    );

    function automatic logic [31:0] m_read(int w);
        if (w == 5)  return {16'h0, cal_period};
        if (w == 6)  return {cal_crs_dly, cal_crs_ref};
        if (w == 7)  return {cal_fin_dly, cal_fin_ref};
        if (w == 11) return m_open ? 32'h0000_AAAA : 32'h0000_AAAB;
        if (w >= 12 && w <= LAST) return m_pin.exists(w) ? m_pin[w] : 32'h0;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        mdl_live = 1;
        if (rst) begin
            m_pin.delete();
            m_open = 0; m_err = 0; m_dbg = 0; e_rv = 0; e_rd = '0;
        end else begin
            int w;
            w = int'(bus_widx);
            e_rv = bus_valid && !bus_write;
            if (bus_valid && !bus_write) e_rd = m_read(w);
            if (bus_valid && bus_write) begin
                if (w == 11) begin
                    if (bus_wdata[15:0] == 16'hAAAA) m_open = 1;
                    else if (bus_wdata[15:0] == 16'hAAAB) m_open = 0;
                end else if (w >= 12 && w <= LAST && m_open) begin
                    logic [31:0] old;
                    old = m_pin.exists(w) ? m_pin[w] : 32'h0;
                    if (bus_wdata[17:12] != 6'h29 || old[10]) m_err = 1;
                    else m_pin[w] = {14'h0, 6'h29, 1'b0, bus_wdata[10:0]};
                end
            end
            if (bus_valid && w >= 12 && w <= LAST) m_dbg = (w - 12) / 3;
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mdl_live && !done) begin
            chk(bus_rvalid === e_rv, "R10", 32'(bus_rvalid), 32'(e_rv));
            chk(bus_rdata === e_rd, cur_req, bus_rdata, e_rd);
            chk(bank_open === m_open, "R2", 32'(bank_open), 32'(m_open));
            chk(cfg_fault === m_err, "R11", 32'(cfg_fault), 32'(m_err));
            chk(int'(dbg_pin) == m_dbg, "R9", 32'(dbg_pin), 32'(m_dbg));
        end
    end

    task automatic op(bit wr, int w, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_widx = AW'(w); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(int w, output logic [31:0] v);
        op(0, w, 32'h0);
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk(bank_open == 0 && cfg_fault == 0 && bus_rvalid == 0 && dbg_pin == 0,
            "R1", {bank_open, cfg_fault, bus_rvalid, 29'(dbg_pin)}, 32'h0);
        chk(bus_rdata == 0, "R1", bus_rdata, 32'h0);
        rd(12, v);  chk(v == 32'h0, "R1", v, 32'h0);

        cur_req = "R3";
        rd(5, v);   chk(v == 32'h0000_1234, "R3", v, 32'h0000_1234);
        rd(6, v);   chk(v == 32'h00A5_0C3C, "R3", v, 32'h00A5_0C3C);
        op(1, 6, 32'hFFFF_FFFF);
        rd(6, v);   chk(v == 32'h00A5_0C3C, "R3", v, 32'h00A5_0C3C);
        rd(7, v);   chk(v == 32'h005A_0F0F, "R3", v, 32'h005A_0F0F);

        cur_req = "R4";
        op(1, 12, 32'h0002_9067);
        rd(12, v);  chk(v == 32'h0, "R4", v, 32'h0);
        chk(cfg_fault == 0, "R4", 32'(cfg_fault), 32'h0);

        cur_req = "R2";
        op(1, 11, 32'h0000_1234);
        chk(bank_open == 0, "R2", 32'(bank_open), 32'h0);
        rd(11, v);  chk(v == 32'h0000_AAAB, "R2", v, 32'h0000_AAAB);
        op(1, 11, 32'hFFFF_AAAA);
        chk(bank_open == 1, "R2", 32'(bank_open), 32'h1);
        rd(11, v);  chk(v == 32'h0000_AAAA, "R2", v, 32'h0000_AAAA);

        cur_req = "R5";
        op(1, 12, 32'hFFFE_9867);
        rd(12, v);  chk(v == 32'h0002_9067, "R5", v, 32'h0002_9067);
        chk(dbg_pin == 0, "R9", 32'(dbg_pin), 32'h0);
        op(1, LAST, 32'h0002_93FF);
        rd(LAST, v); chk(v == 32'h0002_93FF, "R5", v, 32'h0002_93FF);
        chk(dbg_pin == 275, "R9", 32'(dbg_pin), 32'd275);
        rd(15, v);  chk(dbg_pin == 1, "R9", 32'(dbg_pin), 32'd1);

        cur_req = "R7";
        op(1, 20, 32'h0002_9405);
        chk(cfg_fault == 0, "R7", 32'(cfg_fault), 32'h0);
        op(1, 20, 32'h0002_9003);
        rd(20, v);  chk(v == 32'h0002_9405, "R7", v, 32'h0002_9405);
        chk(cfg_fault == 1, "R7", 32'(cfg_fault), 32'h1);
        cur_req = "R11";
        op(1, 21, 32'h0002_9001);
        chk(cfg_fault == 1, "R11", 32'(cfg_fault), 32'h1);
        do_reset();
        @(negedge clk);
        chk(cfg_fault == 0, "R11", 32'(cfg_fault), 32'h0);
        rd(20, v);  chk(v == 32'h0, "R1", v, 32'h0);

        cur_req = "R6";
        op(1, 11, 32'h0000_AAAA);
        op(1, 13, 32'h0002_8067);
        rd(13, v);  chk(v == 32'h0, "R6", v, 32'h0);
        chk(cfg_fault == 1, "R6", 32'(cfg_fault), 32'h1);

        cur_req = "R8";
        op(1, LAST + 1, 32'h0002_9011);
        op(1, 0, 32'h0002_9011);
        chk(dbg_pin == 0, "R9", 32'(dbg_pin), 32'h0);
        rd(LAST + 1, v); chk(v == 32'h0, "R8", v, 32'h0);
        rd(1023, v);     chk(v == 32'h0, "R8", v, 32'h0);
        rd(8, v);        chk(v == 32'h0, "R8", v, 32'h0);
        rd(0, v);        chk(v == 32'h0, "R8", v, 32'h0);

        cur_req = "R4";
        op(1, 11, 32'h0000_AAAB);
        op(1, 30, 32'h0002_9011);
        rd(30, v);  chk(v == 32'h0, "R4", v, 32'h0);

        cur_req = "R5";
        for (int i = 0; i < 500; i++) begin
            int r, w;
            logic [31:0] d;
            r = $urandom_range(0, 9);
            d = $urandom;
            if (r == 0) begin
                w = 11;
                if ($urandom_range(0, 2) == 0) d[15:0] = 16'hAAAB;
                else if ($urandom_range(0, 1) == 0) d[15:0] = 16'hAAAA;
            end else if (r == 1) begin
                w = $urandom_range(5, 7);
            end else if (r == 2) begin
                w = $urandom_range(0, 1023);
            end else begin
                w = 12 + $urandom_range(0, 40);
                if ($urandom_range(0, 9) < 7) d[17:12] = 6'h29;
                d[10] = ($urandom_range(0, 9) == 0);
            end
            op($urandom_range(0, 1) == 1, w, d);
        end

        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tot++; n_bad++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end
endmodule